// File: doc/BRIEF.md
# Multidrop 9-bit Address-Matching UART

This block is a serial port for shared-bus links where many stations listen on one line. A host reaches it over a small register bus with separate read and write strobes. The host sets the mode in a control register and an 8-bit station number in an address register. It then moves characters through a single data register, and it learns why `irq` is high from an interrupt-identification register.

In network mode, every character has a ninth bit that marks it as an address (1) or as data (0). The receiver compares each address character with the station number. A station becomes selected on a match and deselected on any other address. Data characters reach the receive buffer only while the station is selected. The transmitter can put either the address flag or a ninth data bit in the ninth slot. It can also release the line: `txd_en` low tells the pad to go high-impedance.

The receiver and the transmitter are each an enumerated state machine with the states IDLE, START, DATA, NINTH and STOP. Receiver transitions:
- IDLE->START on a low line at a tick.
- START->IDLE on a high line at the mid-start check.
- START->DATA on a low line at that check.
- DATA->NINTH or DATA->STOP after the eighth bit.
- NINTH->STOP after the ninth bit.
- STOP->IDLE at the mid-stop sample.

Transmitter transitions:
- IDLE->START on a load from the holding register.
- START->DATA, DATA->NINTH or STOP, NINTH->STOP, and STOP->IDLE, each after 16 ticks.

A fixed divisor `DIV` produces the 16x oversampling tick, so one bit lasts `16*DIV` clocks.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, `irq` is low, `txd_en` is low, and the ID register (offset 3) reads 9'h001: code 000 in bits 3:1 and the no-interrupt flag in bit 0.
- R2: `txd_en` equals control bit 4 (drive enable). While the transmitter is idle, `txd_out` is 1.
- R3: Writing the data register (offset 0) while the holding register is empty queues one character. The frame sent is a 0 start bit, 8 data bits LSB first, an optional ninth bit, and a 1 stop bit. When control bits 0 (network) and 1 (9-bit transmit) are both set, the ninth bit is present and equals control bit 5 (address flag). Otherwise, if bit 3 (wide) is set, the ninth bit is present and equals write-data bit 8. Otherwise there is no ninth bit.
- R4: A received character is read from offset 0 as {ninth bit, byte}. The ninth bit is expected when bit 3 (wide) is set or when bits 0 and 2 (network, 9-bit receive) are both set. It reads as 0 when no ninth bit is expected.
- R5: With network mode and 9-bit receive on, an address character (ninth bit 1) equal to the station register (offset 2) is stored, selects the station and sets the match condition. A non-equal address character deselects the station and is dropped. Data characters are stored only while the station is selected.
- R6: The match and receive-full conditions only raise `irq` when control bit 6 (receive interrupt enable) is set. A matched address is still stored when that bit is clear.
- R7: The ID register reports only the highest pending enabled source. The sources, in priority order, are: line status (code 011, enable bit 8), address match (110), receive full (010), address transmitted (101), and transmit empty (001). Both transmit sources use enable bit 7. Bit 0 is 1 exactly when none is pending.
- R8: The following reads and writes clear conditions:
  - Reading offset 0 clears receive-full and match.
  - Writing offset 0, or reading offset 3, clears transmit-empty and address-transmitted.
  - Reading the line-status register (offset 4) clears overrun and framing error.
- R9: The line-status register reads as follows:
  - Bit 0 is receive full.
  - Bit 1 is overrun, which is set when a character is stored while the buffer is full. The newer character replaces the older one.
  - Bit 2 is framing error, which is set when the stop bit samples 0. That character is dropped.
  - Bit 3 is holding register empty.
  - Bit 4 is transmitter idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 9 | Write data |
| bus_rdata | output | 9 | Read data, valid while `bus_rd` is high |
| rxd | input | 1 | Serial input |
| txd_out | output | 1 | Serial output value |
| txd_en | output | 1 | Output driver enable; pad is high-impedance when low |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps address characters across the 8-bit space around one station number and follows each one with a data character. A comparator that matched too widely, or never deselected, would leave that data character in the buffer. Transmit frames are decoded bit by bit in 8-bit, wide and address-flag modes, so a misplaced or missing ninth bit shows up as a wrong stop position. Priority is checked by stacking a line-status error on top of a match: an encoder that ranks match first would report 110 before 011. Clearing by a write is observed while the holding register stays full, so a block that did not clear on write would keep reporting transmit-empty.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DW = 9;
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STN  = 3'd2;
    localparam logic [2:0] A_IID  = 3'd3;
    localparam logic [2:0] A_LSR  = 3'd4;

    typedef enum logic [2:0] {
        ID_NONE  = 3'b000,
        ID_TXE   = 3'b001,
        ID_RXF   = 3'b010,
        ID_LS    = 3'b011,
        ID_ATX   = 3'b101,
        ID_MATCH = 3'b110
    } iid_e;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_NINTH, RX_STOP} rx_state_e;

    // first member is the most significant bit: ie_ls is bit 8, net_en bit 0
    typedef struct packed {
        logic ie_ls;
        logic ie_tx;
        logic ie_rx;
        logic txa_flag;
        logic drv_en;
        logic wide;
        logic rx9_en;
        logic tx9_en;
        logic net_en;
    } ctrl_t;
endpackage

// File: rtl/mdu_baud.sv
module mdu_baud #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
    import mdu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] ld_data,
    input  logic       ld_has9,
    input  logic       ld_b9,
    output logic       txd,
    output logic       idle
);
    tx_state_e  state, state_nx;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] shreg;
    logic       has9, b9;
    logic       bit_end;

    assign bit_end = tick && (tcnt == 4'd15);

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (load) state_nx = TX_START;
            TX_START: if (bit_end) state_nx = TX_DATA;
            TX_DATA:  if (bit_end && bidx == 3'd7) state_nx = has9 ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) state_nx = TX_STOP;
            TX_STOP:  if (bit_end) state_nx = TX_IDLE;
            default:  state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            has9  <= 1'b0;
            b9    <= 1'b0;
        end else if (state == TX_IDLE) begin
            tcnt <= '0;
            bidx <= '0;
            if (load) begin
                shreg <= ld_data;
                has9  <= ld_has9;
                b9    <= ld_b9;
            end
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (bit_end && state == TX_DATA) begin
                shreg <= shreg >> 1;
                bidx  <= bidx + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_NINTH: txd = b9;
            default:  txd = 1'b1;
        endcase
        idle = (state == TX_IDLE);
    end
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
    import mdu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       cfg_has9,
    output logic       done,
    output logic       frame_ok,
    output logic [7:0] data,
    output logic       b9
);
    rx_state_e  state, state_nx;
    logic [1:0] sync;
    logic       rxd_s;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic       has9;
    logic       smp;

    assign rxd_s = sync[1];
    assign smp   = tick && (tcnt == 4'd15);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (tick && !rxd_s) state_nx = RX_START;
            RX_START: if (tick && tcnt == 4'd7) state_nx = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (smp && bidx == 3'd7) state_nx = has9 ? RX_NINTH : RX_STOP;
            RX_NINTH: if (smp) state_nx = RX_STOP;
            RX_STOP:  if (smp) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync     <= 2'b11;
            tcnt     <= '0;
            bidx     <= '0;
            has9     <= 1'b0;
            data     <= '0;
            b9       <= 1'b0;
            done     <= 1'b0;
            frame_ok <= 1'b0;
        end else begin
            sync <= {sync[0], rxd};
            done <= (state == RX_STOP) && smp;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        tcnt <= '0;
                        bidx <= '0;
                        has9 <= cfg_has9;
                    end
                    RX_START: tcnt <= (tcnt == 4'd7) ? 4'd0 : tcnt + 1'b1;
                    RX_DATA: begin
                        tcnt <= tcnt + 1'b1;
                        if (smp) begin
                            data <= {rxd_s, data[7:1]};
                            bidx <= bidx + 1'b1;
                            if (bidx == 3'd0) b9 <= 1'b0;
                        end
                    end
                    RX_NINTH: begin
                        tcnt <= tcnt + 1'b1;
                        if (smp) b9 <= rxd_s;
                    end
                    RX_STOP: begin
                        tcnt <= tcnt + 1'b1;
                        if (smp) frame_ok <= rxd_s;
                    end
                    default: tcnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
    import mdu_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rxd,
    output logic          txd_out,
    output logic          txd_en,
    output logic          irq
);
    ctrl_t        ctrl;
    logic [7:0]   stn;
    logic [DW-1:0] rxbuf;
    logic         rx_full, match_p, sel, ovr, fe;
    logic [7:0]   hold;
    logic         hold_full, hold_has9, hold_b9, hold_isaddr;
    logic         txe_p, atx_p;
    logic         tick, tx_idle, tx_load;
    logic         rx_done, rx_ok, rx_b9;
    logic [7:0]   rx_data;
    logic         amode_rx, amode_tx;
    logic         rd_data_stb, wr_data_stb, rd_iid_stb, rd_lsr_stb;
    logic         ls_p, m_p, r_p, a_p, t_p;
    iid_e         iid_code;

    assign amode_rx    = ctrl.net_en && ctrl.rx9_en;
    assign amode_tx    = ctrl.net_en && ctrl.tx9_en;
    assign rd_data_stb = bus_rd && bus_addr == A_DATA;
    assign wr_data_stb = bus_wr && bus_addr == A_DATA;
    assign rd_iid_stb  = bus_rd && bus_addr == A_IID;
    assign rd_lsr_stb  = bus_rd && bus_addr == A_LSR;
    assign tx_load     = hold_full && tx_idle;

    mdu_baud #(.DIV(DIV)) u_baud (.clk(clk), .rst_n(rst_n), .tick(tick));

    mdu_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
        .ld_data(hold), .ld_has9(hold_has9), .ld_b9(hold_b9),
        .txd(txd_out), .idle(tx_idle)
    );

    mdu_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .cfg_has9(amode_rx || ctrl.wide),
        .done(rx_done), .frame_ok(rx_ok), .data(rx_data), .b9(rx_b9)
    );

    // control and station registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            stn  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) ctrl <= ctrl_t'(bus_wdata);
            if (bus_addr == A_STN)  stn  <= bus_wdata[7:0];
        end
    end

    // transmit holding register and its conditions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold        <= '0;
            hold_full   <= 1'b0;
            hold_has9   <= 1'b0;
            hold_b9     <= 1'b0;
            hold_isaddr <= 1'b0;
            txe_p       <= 1'b0;
            atx_p       <= 1'b0;
        end else begin
            if (wr_data_stb || rd_iid_stb) begin
                txe_p <= 1'b0;
                atx_p <= 1'b0;
            end
            if (wr_data_stb && !hold_full) begin
                hold        <= bus_wdata[7:0];
                hold_full   <= 1'b1;
                hold_has9   <= amode_tx || ctrl.wide;
                hold_b9     <= amode_tx ? ctrl.txa_flag : bus_wdata[8];
                hold_isaddr <= amode_tx && ctrl.txa_flag;
            end
            if (tx_load) begin
                hold_full <= 1'b0;
                if (hold_isaddr) atx_p <= 1'b1;
                else             txe_p <= 1'b1;
            end
        end
    end

    // receive buffer, station selection and line status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxbuf   <= '0;
            rx_full <= 1'b0;
            match_p <= 1'b0;
            sel     <= 1'b0;
            ovr     <= 1'b0;
            fe      <= 1'b0;
        end else begin
            if (rd_data_stb) begin
                rx_full <= 1'b0;
                match_p <= 1'b0;
            end
            if (rd_lsr_stb) begin
                ovr <= 1'b0;
                fe  <= 1'b0;
            end
            if (rx_done) begin
                if (!rx_ok) begin
                    fe <= 1'b1;
                end else if (!amode_rx || rx_b9 || sel) begin
                    if (amode_rx && rx_b9 && rx_data != stn) begin
                        sel <= 1'b0;
                    end else begin
                        rxbuf   <= {rx_b9, rx_data};
                        rx_full <= 1'b1;
                        if (rx_full && !rd_data_stb) ovr <= 1'b1;
                        if (amode_rx && rx_b9) begin
                            sel     <= 1'b1;
                            match_p <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // prioritised interrupt identification
    always_comb begin
        ls_p = ctrl.ie_ls && (ovr || fe);
        m_p  = ctrl.ie_rx && match_p;
        r_p  = ctrl.ie_rx && rx_full;
        a_p  = ctrl.ie_tx && atx_p;
        t_p  = ctrl.ie_tx && txe_p;
        if (ls_p)      iid_code = ID_LS;
        else if (m_p)  iid_code = ID_MATCH;
        else if (r_p)  iid_code = ID_RXF;
        else if (a_p)  iid_code = ID_ATX;
        else if (t_p)  iid_code = ID_TXE;
        else           iid_code = ID_NONE;
        irq = ls_p || m_p || r_p || a_p || t_p;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_DATA:  bus_rdata = rxbuf;
                A_CTRL:  bus_rdata = ctrl;
                A_STN:   bus_rdata = {1'b0, stn};
                A_IID:   bus_rdata = {5'd0, iid_code, !irq};
                A_LSR:   bus_rdata = {4'd0, tx_idle, !hold_full, fe, ovr, rx_full};
                default: bus_rdata = '0;
            endcase
        end
    end

    assign txd_en = ctrl.drv_en;
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       ie_any,
    input logic       ie_ls,
    input logic       ovr,
    input logic       fe,
    input logic [2:0] iid_code,
    input logic       match_p,
    input logic       sel,
    input logic       rx_full,
    input logic       rx_done,
    input logic       rd_data_stb,
    input logic       wr_data_stb,
    input logic       hold_full,
    input logic       tx_idle,
    input logic       txd_out
);
    // R1
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_any);

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd_out);

    // R3
    hold_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_stb && !hold_full) |=> hold_full);

    // R5
    match_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_p) |-> sel);

    // R7
    line_status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_ls && (ovr || fe)) |-> iid_code == 3'b011);

    // R8
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_stb && !rx_done) |=> (!rx_full && !match_p));

    // R9
    framing_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe) |-> $past(rx_done));
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .ie_any(ctrl.ie_rx || ctrl.ie_tx || ctrl.ie_ls), .ie_ls(ctrl.ie_ls),
    .ovr(ovr), .fe(fe), .iid_code(iid_code), .match_p(match_p), .sel(sel),
    .rx_full(rx_full), .rx_done(rx_done), .rd_data_stb(rd_data_stb),
    .wr_data_stb(wr_data_stb), .hold_full(hold_full), .tx_idle(tx_idle),
    .txd_out(txd_out)
);

// File: tb/mdrop_uart_tb.sv
module mdrop_uart_tb;
    localparam int DIV = 2;
    localparam int BITC = 16 * DIV;
    localparam logic [8:0] NET = 9'd1, TX9 = 9'd2, RX9 = 9'd4, WIDE = 9'd8, DRV = 9'd16,
                           TXA = 9'd32, IERX = 9'd64, IETX = 9'd128, IELS = 9'd256;
    localparam logic [7:0] STN = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [8:0] bus_wdata = 9'd0;
    logic [8:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd_out, txd_en, irq;
    int         checks = 0, fails = 0;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    mdrop_uart #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
        .txd_out(txd_out), .txd_en(txd_en), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [8:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input bit has9, input bit b9, input bit stopb);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        if (has9) begin
            rxd = b9;
            repeat (BITC) @(negedge clk);
        end
        rxd = stopb;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    // decodes one frame from txd_out: returns {stop, [ninth], data, start}
    task automatic grab(input int nbits, output logic [10:0] f);
        int waited = 0;
        f = '1;
        while (txd_out !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        repeat (BITC / 2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            f[i] = txd_out;
            repeat (BITC) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [8:0]  v;
        logic [10:0] f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 txd_en", int'(txd_en), 0);
        rd(3'd3, v); check("R1 iid", int'(v), 9'h001);
        rd(3'd4, v); check("R9 lsr reset", int'(v), 9'h018);

        // R2 driver enable
        wr(3'd1, DRV);
        @(negedge clk);
        check("R2 txd_en", int'(txd_en), 1);
        check("R2 idle line", int'(txd_out), 1);

        // R3 8-bit frames over a byte sweep
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = 8'((i * 53 + 7) & 255);
            wr(3'd0, {1'b0, b});
            grab(10, f);
            check("R3 8-bit frame", int'(f[9:0]), int'({1'b1, b, 1'b0}));
        end

        // R3 wide data, ninth from write data
        wr(3'd1, DRV | WIDE);
        for (int i = 0; i < 2; i++) begin
            logic [8:0] d;
            d = (i == 0) ? 9'h1A5 : 9'h05A;
            wr(3'd0, d);
            grab(11, f);
            check("R3 wide frame", int'(f), int'({1'b1, d, 1'b0}));
        end

        // R3 / R7 / R8 address flag in network mode
        wr(3'd1, DRV | NET | TX9 | TXA | IETX | WIDE);
        wr(3'd0, 9'h033);
        grab(11, f);
        check("R3 address frame", int'(f), int'({2'b11, 8'h33, 1'b0}));
        rd(3'd3, v); check("R7 addr transmitted id", int'(v), 9'h00A);
        rd(3'd3, v); check("R8 iid read clears", int'(v), 9'h001);
        wr(3'd1, DRV | NET | TX9 | IETX);
        wr(3'd0, 9'h1C4);
        grab(11, f);
        check("R3 data flag frame", int'(f), int'({2'b10, 8'hC4, 1'b0}));
        rd(3'd3, v); check("R7 tx empty id", int'(v), 9'h002);
        wr(3'd1, DRV | IETX);
        wr(3'd0, 9'h011);
        repeat (4) @(negedge clk);
        wr(3'd0, 9'h022);
        @(negedge clk);
        check("R8 write clears tx empty", int'(irq), 0);
        repeat (24 * BITC) @(negedge clk);
        rd(3'd4, v); check("R9 tx drained", int'(v[4:3]), 2'b11);
        rd(3'd3, v); check("R7 tx empty after drain", int'(v), 9'h002);

        // R4 8-bit and wide receive
        wr(3'd1, IERX);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            b = 8'((i * 91 + 3) & 255);
            send(b, 1'b0, 1'b0, 1'b1);
            check("R6 rx irq", int'(irq), 1);
            rd(3'd3, v); check("R7 rx full id", int'(v), 9'h004);
            rd(3'd0, v); check("R4 rx byte", int'(v), int'({1'b0, b}));
            rd(3'd3, v); check("R8 data read clears", int'(v), 9'h001);
        end
        wr(3'd1, IERX | WIDE);
        send(8'h6E, 1'b1, 1'b1, 1'b1);
        rd(3'd0, v); check("R4 wide rx", int'(v), 9'h16E);

        // R5 address sweep
        wr(3'd2, {1'b0, STN});
        wr(3'd1, NET | RX9 | IERX);
        send(8'h3C, 1'b1, 1'b0, 1'b1);
        rd(3'd4, v); check("R5 data before match dropped", int'(v[0]), 0);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] a;
            bit m;
            a = 8'(i * 16 + 12);
            m = (a == STN);
            send(a, 1'b1, 1'b1, 1'b1);
            check("R5 match irq", int'(irq), int'(m));
            if (m) begin
                rd(3'd3, v); check("R7 match id", int'(v), 9'h00C);
                rd(3'd0, v); check("R5 address stored", int'(v), int'({1'b1, a}));
            end
            send(8'h3C, 1'b1, 1'b0, 1'b1);
            rd(3'd4, v); check("R5 data kept only when selected", int'(v[0]), int'(m));
            if (m) begin
                rd(3'd0, v); check("R5 selected data", int'(v), 9'h03C);
            end
        end

        // R6 match without receive interrupt enable
        wr(3'd1, NET | RX9);
        send(STN, 1'b1, 1'b1, 1'b1);
        check("R6 gated irq", int'(irq), 0);
        rd(3'd4, v); check("R6 still stored", int'(v[0]), 1);
        rd(3'd0, v);

        // R9 framing error
        wr(3'd1, IELS | IERX);
        send(8'h55, 1'b0, 1'b0, 1'b0);
        rd(3'd3, v); check("R7 line status id", int'(v), 9'h006);
        rd(3'd4, v); check("R9 framing flag", int'(v[2:0]), 3'b100);
        rd(3'd4, v); check("R8 lsr read clears", int'(v[2:0]), 3'b000);
        rd(3'd3, v); check("R9 framing dropped", int'(v), 9'h001);

        // R7 / R9 overrun above match
        wr(3'd1, NET | RX9 | IERX | IELS);
        send(STN, 1'b1, 1'b1, 1'b1);
        send(8'h3C, 1'b1, 1'b0, 1'b1);
        rd(3'd3, v); check("R7 line status over match", int'(v), 9'h006);
        rd(3'd4, v); check("R9 overrun flag", int'(v[1:0]), 2'b11);
        rd(3'd3, v); check("R7 match over rx full", int'(v), 9'h00C);
        rd(3'd0, v); check("R9 newer char kept", int'(v), 9'h03C);
        rd(3'd3, v); check("R8 all cleared", int'(v), 9'h001);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule